// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Flags

This block recovers asynchronous serial characters from a single receive line. A sample tick running at sixteen times the bit rate and the framing settings arrive as inputs. The line goes through a two-stage synchronizer. A falling edge is confirmed at the middle of the start bit. Then 5 to 8 data bits are collected least significant bit first, followed by an optional parity bit and a stop bit, each sampled at its own mid-bit.

Every finished character goes into a first-word-fall-through queue together with four error flags: framing, parity, break and overrun. A reader sees the head entry as a 12-bit word and pops it with a one-cycle strobe. A separate 4-bit sticky status word collects every error seen, and a write strobe with any value clears it. Bus decode, interrupts, DMA and infrared modes sit outside this block.

Top module: `serial_rx_errq`

## Requirements
- R1: After reset the queue reports empty (`fifo_empty`=1, `fifo_full`=0) and `stat_q` is 0.
- R2: Characters are received only while both `line_en` and `rx_en` are 1. Clearing either one aborts any character in progress, and no entry is written.
- R3: A start is accepted only if the line is still low 8 ticks after the falling edge. A shorter low pulse is dropped, and no entry is written for it.
- R4: `word_len` selects 5/6/7/8 data bits for codes 0/1/2/3. Bits arrive LSB first, and in `rd_data[7:0]` the bits above the word length read 0.
- R5: When `par_en`=1, one parity bit follows the data. The expected value is: even parity when `par_even`=1 and `par_stick`=0; odd parity when both are 0; constant 0 when `par_stick`=1 and `par_even`=1; constant 1 when `par_stick`=1 and `par_even`=0. A mismatch sets `rd_data[9]`.
- R6: A stop bit sampled low sets the framing flag `rd_data[8]`, unless the character is a break.
- R7: A line held low through the start, data, parity and stop bits stores exactly one entry, with data 0 and only the break flag `rd_data[10]` set (parity and framing flags clear). The receiver then waits for the line to return high before it looks for a new start.
- R8: The queue is first-word-fall-through: `rd_data` shows the oldest entry, and `rd_en` pops it. `fifo_full` goes high after DEPTH entries. `rd_en` while empty has no effect.
- R9: A character that completes while the queue is full is dropped. The next entry that is written carries the overrun flag `rd_data[11]`.
- R10: `stat_q` bits are overrun [3], break [2], parity [1] and framing [0]. Each is set when its event occurs and stays set until a `stat_wr` pulse clears all four. An event in the same cycle as the write survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| tick16 | input | 1 | One-cycle pulse at 16x bit rate |
| word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select / stick value select |
| par_stick | input | 1 | Stick parity |
| rxd | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Pop head entry |
| stat_wr | input | 1 | Clear sticky status |
| rd_data | output | 12 | {overrun, break, parity, framing, data[7:0]} |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| stat_q | output | 4 | Sticky {overrun, break, parity, framing} |

## Verification
A character is decided at the tick that marks the middle of its stop bit. It reaches `rd_data` and `stat_q` one clock later. The line change behind that tick entered the synchronizer two clocks earlier still. The bench therefore holds each bit for a full bit period, adds one idle bit, and only then samples the queue and status outputs at a falling clock edge. A pop or a status clear is due at the next rising edge, so its effect is sampled at the falling edge after it. Checks for "nothing happened" wait several bit periods before looking at `fifo_empty`.

// File: rtl/serial_rx_errq.sv
module serial_rx_errq #(
  parameter int DEPTH = 16,
  parameter int SYNC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_en,
  input  logic        rx_en,
  input  logic        tick16,
  input  logic [1:0]  word_len,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        rxd,
  input  logic        rd_en,
  input  logic        stat_wr,
  output logic [11:0] rd_data,
  output logic        fifo_empty,
  output logic        fifo_full,
  output logic [3:0]  stat_q
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  st_t             st;
  logic [3:0]      tcnt;
  logic [2:0]      bcnt;
  logic [7:0]      shf;
  logic            par_bit;
  logic            ovr_pend;
  logic [11:0]     mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;

  wire active   = line_en & rx_en;
  wire mid      = tick16 && (tcnt == 4'd15);
  wire [2:0] last_bit = {1'b1, word_len};
  wire done     = active && (st == S_STOP) && mid;
  wire par_calc = ^shf;
  wire exp_par  = par_stick ? ~par_even : (par_even ? par_calc : ~par_calc);
  wire brk      = (shf == 8'd0) && !rx_s && (!par_en || !par_bit);
  wire fe       = !rx_s && !brk;
  wire pe       = par_en && (par_bit != exp_par) && !brk;
  wire push_ok  = done && !fifo_full;
  wire pop      = rd_en && !fifo_empty;
  wire [3:0] ev = done ? {fifo_full, brk, pe, fe} : 4'd0;

  assign rx_s       = sync_q[SYNC-1];
  assign fifo_empty = (cnt == '0);
  assign fifo_full  = (cnt == CW'(DEPTH));
  assign rd_data    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bcnt    <= '0;
      shf     <= '0;
      par_bit <= 1'b0;
    end else if (!active) begin
      st   <= S_IDLE;
      tcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (!rx_s) begin
          st   <= S_START;
          tcnt <= '0;
          bcnt <= '0;
          shf  <= '0;
        end
        S_START: if (tick16) begin
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else tcnt <= tcnt + 4'd1;
        end
        S_DATA: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            shf[bcnt] <= rx_s;
            if (bcnt == last_bit) st <= par_en ? S_PAR : S_STOP;
            else bcnt <= bcnt + 3'd1;
          end
        end
        S_PAR: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            par_bit <= rx_s;
            st      <= S_STOP;
          end
        end
        S_STOP: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) st <= rx_s ? S_IDLE : S_HOLD;
        end
        S_HOLD: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= {ovr_pend, brk, pe, fe, shf};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      ovr_pend <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (pop)     rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (done) ovr_pend <= fifo_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_wr) stat_q <= ev;
    else              stat_q <= stat_q | ev;
  end

  // R8
  empty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));

  // R2
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (st == S_IDLE));

  // R3
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == S_START && tick16 && tcnt == 4'd7 && rx_s) |=> (st == S_IDLE));

  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_pend && !done) |=> ovr_pend);

  // R10
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !done) |=> (stat_q == 4'd0));

endmodule

// File: tb/test_serial_rx_errq.sv
module test_serial_rx_errq;
  localparam int CLK_PERIOD = 10;
  localparam int BITCLK     = 64;
  localparam int DEPTH      = 4;

  typedef struct packed {
    logic [1:0]  wl;
    logic        pen, pev, pst, flip, stop;
    logic [7:0]  dat;
    logic [11:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 12'h0A5},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 12'h03C},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 12'h23C},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 12'h055},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1F, 12'h11F},
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 12'h281},
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h7E, 12'h07E},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 12'h03F}
  };

  logic clk = 0, rst_n = 0, line_en = 0, rx_en = 0, tick16 = 0;
  logic [1:0] word_len = 2'd3;
  logic par_en = 0, par_even = 0, par_stick = 0, rxd = 1, rd_en = 0, stat_wr = 0;
  logic [11:0] rd_data;
  logic fifo_empty, fifo_full;
  logic [3:0] stat_q;
  logic [1:0] tdiv = 0;
  int n_run = 0, n_fail = 0;

  serial_rx_errq #(.DEPTH(DEPTH), .SYNC(2)) i_serial_rx_errq (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .rx_en(rx_en), .tick16(tick16),
    .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rxd(rxd), .rd_en(rd_en), .stat_wr(stat_wr), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .stat_q(stat_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    wait_clk(BITCLK);
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb,
                                  input logic ev, input logic st);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    if (st) return ~ev;
    return ev ? x : ~x;
  endfunction

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                            input logic pb, input logic stp);
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pen) send_bit(pb);
    send_bit(stp);
    send_bit(1'b1);
  endtask

  task automatic send8(input logic [7:0] d);
    send_frame(d, 8, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic pop1;
    rd_en = 1;
    wait_clk(1);
    rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    // R1 reset state
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 stat", stat_q, 0);
    line_en = 1;
    rx_en   = 1;
    wait_clk(BITCLK);

    // R4 R5 R6 table of frames
    foreach (VECS[k]) begin
      int nb;
      logic pb;
      word_len  = VECS[k].wl;
      par_en    = VECS[k].pen;
      par_even  = VECS[k].pev;
      par_stick = VECS[k].pst;
      nb = 5 + int'(VECS[k].wl);
      pb = par_of(VECS[k].dat, nb, VECS[k].pev, VECS[k].pst) ^ VECS[k].flip;
      send_frame(VECS[k].dat, nb, VECS[k].pen, pb, VECS[k].stop);
      chk("R4/R5/R6 entry present", fifo_empty, 0);
      chk("R4/R5/R6 rd_data", rd_data, VECS[k].exp);
      pop1();
      chk("R8 empty after pop", fifo_empty, 1);
    end

    // R10 sticky status then clear
    chk("R10 sticky PE|FE", stat_q, 4'b0011);
    stat_wr = 1;
    wait_clk(1);
    stat_wr = 0;
    chk("R10 cleared", stat_q, 0);

    word_len = 2'd3;
    par_en = 0;
    par_even = 0;
    par_stick = 0;

    // R3 glitch
    rxd = 0;
    wait_clk(16);
    rxd = 1;
    wait_clk(BITCLK * 12);
    chk("R3 glitch dropped", fifo_empty, 1);

    // R2 disabled receive
    rx_en = 0;
    send8(8'h5A);
    chk("R2 rx_en off", fifo_empty, 1);
    rx_en = 1;
    line_en = 0;
    send8(8'h5A);
    chk("R2 line_en off", fifo_empty, 1);
    line_en = 1;
    wait_clk(BITCLK);

    // R8 pop while empty is ignored
    pop1();
    send8(8'hC3);
    chk("R8 after empty pop", rd_data, 12'h0C3);
    pop1();
    chk("R8 single entry", fifo_empty, 1);

    // R7 break
    rxd = 0;
    wait_clk(BITCLK * 14);
    chk("R7 one entry during hold", fifo_empty, 0);
    rxd = 1;
    wait_clk(BITCLK * 2);
    chk("R7 break entry", rd_data, 12'h400);
    chk("R10 break sticky", stat_q, 4'b0100);
    pop1();
    chk("R7 only one entry", fifo_empty, 1);
    stat_wr = 1;
    wait_clk(1);
    stat_wr = 0;

    // R9 overrun
    send8(8'h11);
    send8(8'h22);
    send8(8'h33);
    send8(8'h44);
    chk("R8 full", fifo_full, 1);
    send8(8'h55);
    chk("R9 status overrun", stat_q, 4'b1000);
    chk("R9 still full", fifo_full, 1);
    chk("R8 head order", rd_data, 12'h011);
    pop1();
    send8(8'h66);
    chk("R9 entry 2", rd_data, 12'h022);
    pop1();
    chk("R9 entry 3", rd_data, 12'h033);
    pop1();
    chk("R9 entry 4", rd_data, 12'h044);
    pop1();
    chk("R9 flagged entry", rd_data, 12'h866);
    pop1();
    chk("R9 drained", fifo_empty, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule